// File: doc/BRIEF.md
# Event-Count Interrupt Prescaler

This block sits between an event selector and an interrupt controller. It counts qualified trigger events arriving on a single-cycle strobe. When the count reaches a programmable period, it raises a one-cycle interrupt request. A sticky pending flag gates generation: once an interrupt has been raised, no new one is produced until software clears the flag. The counter then holds at the period, so the next event after the clear fires at once.

Software programs the block through a small write port and reads it back through a combinational read port. The configuration word holds an enable bit in bit 0 and a width-select bit in bit 1. With the width-select bit at 0, only the low two bits of the period are used. With it at 1, all four bits are used. The period word is at address 1. Address 2 is the command and status word. On a write, bit 0 clears the flag and bit 1 forces an interrupt. On a read, bit 0 is the flag and bits 7:4 are the event count. Software may rewrite the period while counting is in progress, and each such rewrite has a defined effect on the count and on firing.

Top module: `ecip_prescaler`

## Requirements
- R1: After reset the event count, the pending flag, the interrupt output, the configuration word (address 0) and the period word (address 1) all read as zero.
- R2: With configuration bit 1 at 0, the effective period is the low two bits of the period word. A value of 0 stops counting: the count holds and no interrupt is raised. A value of 1, 2 or 3 raises the interrupt on that numbered event.
- R3: With configuration bit 1 at 1, the effective period is the full four-bit period word. The count runs from 0 to 15 and reads back in status bits 7:4.
- R4: An interrupt is raised only while the enable bit (configuration bit 0) is 1 and the flag is 0. The output irq_o is high for one cycle, in the cycle after the clock edge that samples the event, and the flag becomes 1 in that same cycle.
- R5: When an interrupt is raised from counting, the count returns to zero.
- R6: While generation is blocked, by a set flag or by a zero enable bit, the count stops at the effective period. The first event after the block is lifted raises the interrupt.
- R7: A period write without an event, whose effective value equals the current count, sets the count to zero. It also raises the interrupt if the value is non-zero, the enable bit is 1 and the flag is 0.
- R8: A period write without an event, whose effective value is greater than the count, sets the count to zero without an interrupt. A smaller value leaves the count frozen, ignoring events, until the period is rewritten.
- R9: An event in the same cycle as a period write, of any value, increments the count (saturating at 15) and raises no interrupt from counting in that cycle.
- R10: Writing 1 to command bit 1 raises the interrupt and sets the flag when the effective period is non-zero and the enable bit is 1, leaving the count as events alone move it. Otherwise the write is ignored.
- R11: Writing 1 to command bit 0 clears the flag. If an interrupt is raised in the same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | Qualified event strobe, one per cycle at most |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 config, 1 period, 2 command |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 config, 1 period, 2 status |
| rd_data | output | 8 | Combinational read data |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
Counting events and servicing the flag can land in the same cycle. The bench provokes this in several ways: an event together with a clear write, a force write combined with a clear, an event during a period write, and an event during a force write. Each cycle is judged against a behavioural model. The model settles period writes first, then counting, and lets a set of the flag win over a clear. Its count, flag and interrupt are compared with the status read and irq_o after every clock.

// File: rtl/ecip_pkg.sv
package ecip_pkg;
  // register addresses
  localparam int REG_CFG = 0;
  localparam int REG_PER = 1;
  localparam int REG_CMD = 2;
  // bit positions inside the config and command words
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_WIDE_BIT = 1;
  localparam int CMD_CLR_BIT  = 0;
  localparam int CMD_FRC_BIT  = 1;
endpackage

// File: rtl/ecip_regs.sv
module ecip_regs
  import ecip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq_en,
  output logic              wide_mode,
  output logic [CNT_W-1:0]  period,
  output logic              per_wr,
  output logic [CNT_W-1:0]  per_wr_val,
  output logic              clr_req,
  output logic              frc_req
);
  logic sel_cfg, sel_cmd;
  logic unused_hi;

  assign sel_cfg    = wr_en && (wr_addr == ADDR_W'(REG_CFG));
  assign per_wr     = wr_en && (wr_addr == ADDR_W'(REG_PER));
  assign sel_cmd    = wr_en && (wr_addr == ADDR_W'(REG_CMD));
  assign per_wr_val = wr_data[CNT_W-1:0];
  assign clr_req    = sel_cmd && wr_data[CMD_CLR_BIT];
  assign frc_req    = sel_cmd && wr_data[CMD_FRC_BIT];
  assign unused_hi  = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en    <= 1'b0;
      wide_mode <= 1'b0;
      period    <= '0;
    end else begin
      if (sel_cfg) begin
        irq_en    <= wr_data[CFG_EN_BIT];
        wide_mode <= wr_data[CFG_WIDE_BIT];
      end
      if (per_wr) period <= per_wr_val;
    end
  end
endmodule

// File: rtl/ecip_counter.sv
module ecip_counter #(
  parameter int CNT_W   = 4,
  parameter int SHORT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             wide_mode,
  input  logic [CNT_W-1:0] period,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_wr_val,
  input  logic             irq_en,
  input  logic             flag,
  input  logic             frc_req,
  output logic [CNT_W-1:0] count,
  output logic             gen_evt,
  output logic             frc_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // period as seen by the comparator in the current width mode
  function automatic logic [CNT_W-1:0] eff_period(input logic [CNT_W-1:0] p,
                                                  input logic wide);
    logic [CNT_W-1:0] narrow;
    narrow = '0;
    narrow[SHORT_W-1:0] = p[SHORT_W-1:0];
    return wide ? p : narrow;
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  logic [CNT_W-1:0] cur_p, new_p, stepped, cnt_nxt;
  logic             gate_open;

  assign cur_p     = eff_period(period, wide_mode);
  assign new_p     = eff_period(per_wr_val, wide_mode);
  assign gate_open = irq_en && !flag;
  assign stepped   = (count < cur_p) ? count + 1'b1 : count;
  assign frc_hit   = frc_req && irq_en && (cur_p != '0);

  always_comb begin
    cnt_nxt = count;
    gen_evt = 1'b0;
    if (per_wr) begin
      if (evt_i) begin
        cnt_nxt = sat_inc(count);
      end else if (new_p == count) begin
        cnt_nxt = '0;
        gen_evt = (new_p != '0) && gate_open;
      end else if (new_p > count) begin
        cnt_nxt = '0;
      end
    end else if (evt_i && (cur_p != '0) && (count <= cur_p)) begin
      if (stepped == cur_p) begin
        if (gate_open) begin
          gen_evt = 1'b1;
          cnt_nxt = '0;
        end else begin
          cnt_nxt = cur_p;
        end
      end else begin
        cnt_nxt = stepped;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_nxt;
  end
endmodule

// File: rtl/ecip_flag.sv
module ecip_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic gen_evt,
  input  logic frc_hit,
  input  logic clr_req,
  output logic flag,
  output logic irq_o
);
  logic set_req;
  assign set_req = gen_evt || frc_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= set_req;
      if (set_req)      flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ecip_prescaler.sv
module ecip_prescaler
  import ecip_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2,
  parameter int CNT_W   = 4,
  parameter int SHORT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o
);
  logic             irq_en, wide_mode, per_wr, clr_req, frc_req;
  logic [CNT_W-1:0] period, per_wr_val, count;
  logic             gen_evt, frc_hit, flag;

  ecip_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_en(irq_en), .wide_mode(wide_mode), .period(period), .per_wr(per_wr),
    .per_wr_val(per_wr_val), .clr_req(clr_req), .frc_req(frc_req)
  );

  ecip_counter #(.CNT_W(CNT_W), .SHORT_W(SHORT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wide_mode(wide_mode), .period(period),
    .per_wr(per_wr), .per_wr_val(per_wr_val), .irq_en(irq_en), .flag(flag),
    .frc_req(frc_req), .count(count), .gen_evt(gen_evt), .frc_hit(frc_hit)
  );

  ecip_flag u_flag (
    .clk(clk), .rst_n(rst_n), .gen_evt(gen_evt), .frc_hit(frc_hit),
    .clr_req(clr_req), .flag(flag), .irq_o(irq_o)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(REG_CFG)) begin
      rd_data[CFG_EN_BIT]   = irq_en;
      rd_data[CFG_WIDE_BIT] = wide_mode;
    end else if (rd_addr == ADDR_W'(REG_PER)) begin
      rd_data[CNT_W-1:0] = period;
    end else if (rd_addr == ADDR_W'(REG_CMD)) begin
      rd_data[0]                = flag;
      rd_data[DATA_W-1 -: CNT_W] = count;
    end
  end
endmodule

// File: rtl/ecip_checker.sv
module ecip_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_i,
  input logic             irq_o,
  input logic             irq_en,
  input logic             flag,
  input logic [CNT_W-1:0] count,
  input logic             gen_evt,
  input logic             frc_hit,
  input logic             clr_req
);
  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag); // R4

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(irq_en)); // R4

  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    gen_evt |=> (count == '0)); // R5

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_evt || frc_hit) |=> flag); // R11

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !gen_evt && !frc_hit) |=> !flag); // R11

  AST_FORCE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_hit && !evt_i) |=> $stable(count)); // R10
endmodule

bind ecip_prescaler ecip_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .irq_o(irq_o), .irq_en(irq_en),
  .flag(flag), .count(count), .gen_evt(gen_evt), .frc_hit(frc_hit), .clr_req(clr_req)
);

// File: tb/ecip_prescaler_bench.sv
module ecip_prescaler_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd2;
  logic [7:0] rd_data;
  logic       irq;

  ecip_prescaler u_ecip_prescaler (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  int    m_en = 0, m_wide = 0, m_per = 0, m_cnt = 0, m_flag = 0, m_irq = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(int p);
    return (m_wide != 0) ? (p % 16) : (p % 4);
  endfunction

  // behavioural reference: period writes, then counting, then flag
  task automatic model(bit e, bit we, int a, int d);
    int  p;
    int  np;
    int  s;
    bit  fire;
    bit  frc;
    bit  clr;
    p = eff(m_per);
    fire = 0; frc = 0; clr = 0;
    if (we && a == 1) begin
      np = eff(d % 16);
      if (e) m_cnt = (m_cnt < 15) ? m_cnt + 1 : 15;
      else if (np == m_cnt) begin
        m_cnt = 0;
        fire = (np != 0) && (m_en != 0) && (m_flag == 0);
      end else if (np > m_cnt) m_cnt = 0;
      m_per = d % 16;
    end else if (e && p != 0 && m_cnt <= p) begin
      s = (m_cnt < p) ? m_cnt + 1 : m_cnt;
      if (s == p) begin
        if (m_en != 0 && m_flag == 0) begin
          fire = 1;
          m_cnt = 0;
        end else m_cnt = p;
      end else m_cnt = s;
    end
    if (we && a == 2) begin
      clr = (d % 2) == 1;
      frc = ((d / 2) % 2 == 1) && (p != 0) && (m_en != 0);
    end
    if (we && a == 0) begin
      m_en = d % 2;
      m_wide = (d / 2) % 2;
    end
    m_irq = (fire || frc) ? 1 : 0;
    if (fire || frc) m_flag = 1;
    else if (clr) m_flag = 0;
  endtask

  task automatic cyc(bit e, bit we, int a, int d);
    evt = e; wr_en = we; wr_addr = a[1:0]; wr_data = d[7:0];
    @(posedge clk);
    model(e, we, a, d);
    @(negedge clk);
    evt = 1'b0; wr_en = 1'b0;
    check(irq == m_irq[0], cur_req, "irq_o", int'(irq), m_irq);
    check(rd_data[0] == m_flag[0], cur_req, "flag", int'(rd_data[0]), m_flag);
    check(int'(rd_data[7:4]) == m_cnt, cur_req, "count", int'(rd_data[7:4]), m_cnt);
  endtask

  task automatic ev(int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 0, 0);
  endtask
  task automatic wcfg(int en, int wide); cyc(1'b0, 1'b1, 0, en + 2 * wide); endtask
  task automatic wper(int v);            cyc(1'b0, 1'b1, 1, v);            endtask
  task automatic wcmd(int c, int f);     cyc(1'b0, 1'b1, 2, c + 2 * f);    endtask

  // hand-worked expectation of count and flag
  task automatic expect_state(string req, int cnt, int flg);
    check(int'(rd_data[7:4]) == cnt, req, "hand count", int'(rd_data[7:4]), cnt);
    check(int'(rd_data[0]) == flg, req, "hand flag", int'(rd_data[0]), flg);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog %s actual=running expected=finished", cur_req);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cur_req = "R1";
    rd_addr = 2'd0; #1;
    check(rd_data == 8'd0, "R1", "config", int'(rd_data), 0);
    rd_addr = 2'd1; #1;
    check(rd_data == 8'd0, "R1", "period", int'(rd_data), 0);
    rd_addr = 2'd2; #1;
    check(rd_data == 8'd0, "R1", "status", int'(rd_data), 0);
    check(irq == 1'b0, "R1", "irq_o", int'(irq), 0);

    // R2 short mode
    cur_req = "R2";
    wcfg(1, 0);
    ev(3);             expect_state("R2", 0, 0);
    cur_req = "R10";
    wcmd(0, 1);        expect_state("R10", 0, 0);
    cur_req = "R2";
    wper(1); ev(1);    expect_state("R2", 0, 1);
    wcmd(1, 0);
    wper(2); ev(1);    expect_state("R2", 1, 0);
    ev(1);             expect_state("R2", 0, 1);
    wcmd(1, 0);
    wper(3); ev(2);    expect_state("R2", 2, 0);
    ev(1);             expect_state("R2", 0, 1);
    wcmd(1, 0);
    wper(5); ev(1);    expect_state("R2", 0, 1);
    wcmd(1, 0);

    // R3 wide mode
    cur_req = "R3";
    wcfg(1, 1);
    wper(9); ev(8);    expect_state("R3", 8, 0);
    ev(1);             expect_state("R3", 0, 1);
    wcmd(1, 0);
    wper(15); ev(14);  expect_state("R3", 14, 0);
    ev(1);             expect_state("R3", 0, 1);
    wcmd(1, 0);
    rd_addr = 2'd1; #1;
    check(rd_data == 8'd15, "R3", "period readback", int'(rd_data), 15);
    rd_addr = 2'd2;

    // R6 blocked generation
    cur_req = "R6";
    wper(2); ev(2);    expect_state("R6", 0, 1);
    ev(4);             expect_state("R6", 2, 1);
    wcmd(1, 0);        expect_state("R6", 2, 0);
    ev(1);             expect_state("R6", 0, 1);
    wcmd(1, 0);
    cur_req = "R4";
    wcfg(0, 1); ev(3); expect_state("R4", 2, 0);
    check(irq == 1'b0, "R4", "irq while disabled", int'(irq), 0);
    wcfg(1, 1); ev(1); expect_state("R6", 0, 1);
    wcmd(1, 0);

    // R7 period write equal to count
    cur_req = "R7";
    wper(6); ev(3);    expect_state("R7", 3, 0);
    wper(3);           expect_state("R7", 0, 1);
    ev(2);             expect_state("R7", 2, 1);
    wper(2);           expect_state("R7", 0, 1);
    wcmd(1, 0);

    // R8 greater and smaller period writes
    cur_req = "R8";
    wper(10); ev(6);   expect_state("R8", 6, 0);
    wper(4);           expect_state("R8", 6, 0);
    ev(3);             expect_state("R8", 6, 0);
    wper(8);           expect_state("R8", 0, 0);
    ev(2); wper(12);   expect_state("R8", 0, 0);

    // R9 event during period write
    cur_req = "R9";
    wper(5); ev(2);
    cyc(1'b1, 1'b1, 1, 3); expect_state("R9", 3, 0);
    cur_req = "R5";
    ev(1);             expect_state("R5", 0, 1);
    wcmd(1, 0);
    cur_req = "R9";
    ev(1);
    cyc(1'b1, 1'b1, 1, 0); expect_state("R9", 2, 0);
    ev(2);             expect_state("R9", 2, 0);

    // R10 force
    cur_req = "R10";
    wper(4); ev(1);    expect_state("R10", 1, 0);
    wcmd(0, 1);        expect_state("R10", 1, 1);
    cyc(1'b1, 1'b1, 2, 2); expect_state("R10", 2, 1);
    wcmd(1, 0);
    wcfg(0, 1);
    wcmd(0, 1);        expect_state("R10", 2, 0);
    wcfg(1, 1);

    // R11 clear against a set in the same cycle
    cur_req = "R11";
    ev(1);             expect_state("R11", 3, 0);
    cyc(1'b1, 1'b1, 2, 1); expect_state("R11", 0, 1);
    wcmd(1, 1);        expect_state("R11", 0, 1);
    wcmd(1, 0);        expect_state("R11", 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule